// File: doc/BRIEF.md
# Domain-Steered Opcode Dispatch and Trap Unit

This block sits at the decode stage of a pipelined processor. It sorts every decoded opcode onto one of four paths: direct hardware execution, the microcode sequencer, a software handler, or rejection. The path for each opcode comes from a per-domain route table that software loads at run time. Any opcode may be given the software path, including one the hardware could execute itself. Switching the active domain swaps the whole table in a single write, with no cost beyond an ordinary register update.

When an opcode takes the software path, the block copies the opcode, the instruction fields and both operand values into a separate shadow register bank. In the same cycle it injects a branch to a vector address, which is the trap base plus the opcode shifted left by four. The handler runs on the shadow bank, so the primary registers are never saved or restored. The handler signals the end of its work on a return input. If a second software-path opcode arrives while the shadow bank is still owned, decode is held until that return. A disabled opcode raises an illegal-operation pulse and keeps its opcode for inspection.

The control is a three-state machine. `S_FREE` means the shadow bank is idle. `S_VECTOR` is the one cycle in which the shadow write and the injected branch are issued. `S_OWNED` means the handler holds the bank. The transitions are:
- `S_FREE -> S_VECTOR` on an accepted trap.
- `S_VECTOR -> S_OWNED` always, after one cycle.
- `S_OWNED -> S_FREE` on handler return.

Top module: `opdisp_trap_unit`

## Requirements
- R1: An accepted instruction (`dec_valid` and `dec_ready` high at a clock edge) gives `rt_valid`=1 in the next cycle, with `rt_class` set to the route code: 0 hardware, 1 microcode, 2 software trap, 3 disabled.
- R2: There are four route tables, one per domain. `tbl_we` writes the code `tbl_route` for opcode `tbl_opc` into domain `tbl_dom`. Classification uses the domain last loaded through `dom_we`/`dom_sel`.
- R3: A table write or a domain switch in the same cycle as an accepted instruction does not affect that instruction. It applies from the next accepted instruction onward.
- R4: In the cycle after a trap is accepted, `shb_we`=1 for exactly one cycle, and the shadow data ports carry that instruction's opcode, fields and both operands.
- R5: In the same cycle as `shb_we`, `inj_valid`=1 and `inj_target` equals the trap base register plus the opcode shifted left by 4. The trap base is loaded by `base_we`.
- R6: `dec_ready` is low during the cycle in which the vectored branch is injected.
- R7: A disabled opcode gives `ill_valid`=1 for one cycle. `ill_opcode` holds that opcode until the next disabled opcode. No shadow write and no injected branch occur.
- R8: Hardware and microcode opcodes are accepted back-to-back at one per cycle, both when the shadow bank is idle and when it is owned by a handler.
- R9: A trap opcode presented while the shadow bank is owned keeps `dec_ready` low until `hdl_return`. It is accepted in the cycle after the return.
- R10: After reset, every table entry is hardware, the domain and the trap base are 0, `dec_ready` is 1, and all output strobes and `ill_opcode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | A decoded instruction is presented |
| dec_opcode | input | 8 | Decoded opcode |
| dec_fields | input | 16 | Decoded instruction fields |
| dec_opa | input | 32 | First operand value |
| dec_opb | input | 32 | Second operand value |
| dec_ready | output | 1 | Decode may advance |
| tbl_we | input | 1 | Route table write strobe |
| tbl_dom | input | 2 | Domain whose table is written |
| tbl_opc | input | 8 | Opcode entry being written |
| tbl_route | input | 2 | Route code written |
| dom_we | input | 1 | Active domain load strobe |
| dom_sel | input | 2 | New active domain |
| base_we | input | 1 | Trap base load strobe |
| base_val | input | 32 | New trap base address |
| hdl_return | input | 1 | Handler has finished and frees the shadow bank |
| rt_valid | output | 1 | Route result is valid |
| rt_class | output | 2 | Route code of the accepted instruction |
| shb_we | output | 1 | Shadow bank write strobe |
| shb_opcode | output | 8 | Opcode written to the shadow bank |
| shb_fields | output | 16 | Fields written to the shadow bank |
| shb_opa | output | 32 | First operand written to the shadow bank |
| shb_opb | output | 32 | Second operand written to the shadow bank |
| inj_valid | output | 1 | Injected branch is valid |
| inj_target | output | 32 | Vector address of the injected branch |
| ill_valid | output | 1 | Illegal-operation exception pulse |
| ill_opcode | output | 8 | Opcode of the last disabled instruction |

## Verification
Eight table-driven cases run the same opcodes through different domains, so that a domain-select error and a wrong table read give different codes. Same-cycle writes and domain switches show whether an update leaks into the instruction already in decode. Traps are tried with two bases and two opcodes, which exposes shift and add errors in the vector. A trap held behind an owned shadow bank, with a non-trap opcode accepted in between, separates a stall that is too broad from one that is missing.

// File: rtl/opdisp_pkg.sv
package opdisp_pkg;

    typedef enum logic [1:0] {
        RT_HW    = 2'b00,
        RT_MICRO = 2'b01,
        RT_TRAP  = 2'b10,
        RT_OFF   = 2'b11
    } route_e;

    typedef enum logic [1:0] {
        S_FREE   = 2'b00,
        S_VECTOR = 2'b01,
        S_OWNED  = 2'b10
    } shb_state_e;

endpackage

// File: rtl/opdisp_table.sv
module opdisp_table
    import opdisp_pkg::*;
#(
    parameter int OPC_W = 8,
    parameter int NDOM  = 4,
    localparam int DOM_W = $clog2(NDOM),
    localparam int NOPC  = 1 << OPC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DOM_W-1:0] wr_dom,
    input  logic [OPC_W-1:0] wr_opc,
    input  route_e           wr_route,
    input  logic [DOM_W-1:0] rd_dom,
    input  logic [OPC_W-1:0] rd_opc,
    output route_e           rd_route
);

    route_e dom_rd [NDOM];

    for (genvar d = 0; d < NDOM; d++) begin : g_bank
        route_e mem [NOPC];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < NOPC; i++) begin
                    mem[i] <= RT_HW;
                end
            end else if (wr_en && (wr_dom == DOM_W'(d))) begin
                mem[wr_opc] <= wr_route;
            end
        end

        assign dom_rd[d] = mem[rd_opc];
    end

    assign rd_route = dom_rd[rd_dom];

endmodule

// File: rtl/opdisp_fsm.sv
module opdisp_fsm
    import opdisp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dec_valid,
    input  route_e     cur_cls,
    input  logic       hdl_return,
    output logic       dec_ready,
    output logic       trap_take,
    output shb_state_e st
);

    shb_state_e st_q, st_d;
    logic       accept;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_FREE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_FREE:   if (trap_take)  st_d = S_VECTOR;
            S_VECTOR:                 st_d = S_OWNED;
            S_OWNED:  if (hdl_return) st_d = S_FREE;
            default:                  st_d = S_FREE;
        endcase
    end

    always_comb begin
        dec_ready = 1'b1;
        unique case (st_q)
            S_FREE:   dec_ready = 1'b1;
            S_VECTOR: dec_ready = 1'b0;
            S_OWNED:  dec_ready = !(dec_valid && cur_cls == RT_TRAP);
            default:  dec_ready = 1'b0;
        endcase
    end

    assign accept    = dec_valid && dec_ready;
    assign trap_take = accept && (cur_cls == RT_TRAP);
    assign st        = st_q;

    // R8: an idle shadow bank never holds decode
    a_r8_free_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_FREE) |-> dec_ready);

    // R9: the owner leaves only on handler return
    a_r9_owned_until_return: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_OWNED && !hdl_return) |=> (st_q == S_OWNED));

    // R6: the vector state lasts a single cycle
    a_r6_vector_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_VECTOR) |=> (st_q == S_OWNED));

endmodule

// File: rtl/opdisp_trap_unit.sv
module opdisp_trap_unit
    import opdisp_pkg::*;
#(
    parameter int OPC_W  = 8,
    parameter int FLD_W  = 16,
    parameter int DAT_W  = 32,
    parameter int ADR_W  = 32,
    parameter int NDOM   = 4,
    parameter int VEC_SH = 4,
    localparam int DOM_W = $clog2(NDOM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_valid,
    input  logic [OPC_W-1:0] dec_opcode,
    input  logic [FLD_W-1:0] dec_fields,
    input  logic [DAT_W-1:0] dec_opa,
    input  logic [DAT_W-1:0] dec_opb,
    output logic             dec_ready,
    input  logic             tbl_we,
    input  logic [DOM_W-1:0] tbl_dom,
    input  logic [OPC_W-1:0] tbl_opc,
    input  logic [1:0]       tbl_route,
    input  logic             dom_we,
    input  logic [DOM_W-1:0] dom_sel,
    input  logic             base_we,
    input  logic [ADR_W-1:0] base_val,
    input  logic             hdl_return,
    output logic             rt_valid,
    output logic [1:0]       rt_class,
    output logic             shb_we,
    output logic [OPC_W-1:0] shb_opcode,
    output logic [FLD_W-1:0] shb_fields,
    output logic [DAT_W-1:0] shb_opa,
    output logic [DAT_W-1:0] shb_opb,
    output logic             inj_valid,
    output logic [ADR_W-1:0] inj_target,
    output logic             ill_valid,
    output logic [OPC_W-1:0] ill_opcode
);

    logic [DOM_W-1:0] dom_q;
    logic [ADR_W-1:0] base_q;
    route_e           cur_cls;
    shb_state_e       st;
    logic             trap_take;
    logic             accept;

    logic             rt_valid_q;
    route_e           rt_class_q;
    logic             ill_valid_q;
    logic [OPC_W-1:0] ill_opc_q;
    logic [OPC_W-1:0] cap_opc_q;
    logic [FLD_W-1:0] cap_fld_q;
    logic [DAT_W-1:0] cap_a_q;
    logic [DAT_W-1:0] cap_b_q;
    logic [ADR_W-1:0] tgt_q;

    opdisp_table #(
        .OPC_W (OPC_W),
        .NDOM  (NDOM)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_dom   (tbl_dom),
        .wr_opc   (tbl_opc),
        .wr_route (route_e'(tbl_route)),
        .rd_dom   (dom_q),
        .rd_opc   (dec_opcode),
        .rd_route (cur_cls)
    );

    opdisp_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_valid  (dec_valid),
        .cur_cls    (cur_cls),
        .hdl_return (hdl_return),
        .dec_ready  (dec_ready),
        .trap_take  (trap_take),
        .st         (st)
    );

    assign accept = dec_valid && dec_ready;

    // architectural control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dom_q  <= '0;
            base_q <= '0;
        end else begin
            if (dom_we)  dom_q  <= dom_sel;
            if (base_we) base_q <= base_val;
        end
    end

    // route result and exception capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_valid_q  <= 1'b0;
            rt_class_q  <= RT_HW;
            ill_valid_q <= 1'b0;
            ill_opc_q   <= '0;
        end else begin
            rt_valid_q  <= accept;
            if (accept) rt_class_q <= cur_cls;
            ill_valid_q <= accept && (cur_cls == RT_OFF);
            if (accept && cur_cls == RT_OFF) ill_opc_q <= dec_opcode;
        end
    end

    // trap capture for shadow bank and vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_opc_q <= '0;
            cap_fld_q <= '0;
            cap_a_q   <= '0;
            cap_b_q   <= '0;
            tgt_q     <= '0;
        end else if (trap_take) begin
            cap_opc_q <= dec_opcode;
            cap_fld_q <= dec_fields;
            cap_a_q   <= dec_opa;
            cap_b_q   <= dec_opb;
            tgt_q     <= base_q + (ADR_W'(dec_opcode) << VEC_SH);
        end
    end

    // outputs from state
    always_comb begin
        shb_we    = 1'b0;
        inj_valid = 1'b0;
        unique case (st)
            S_FREE:   ;
            S_VECTOR: begin
                shb_we    = 1'b1;
                inj_valid = 1'b1;
            end
            S_OWNED:  ;
            default:  ;
        endcase
    end

    assign shb_opcode = cap_opc_q;
    assign shb_fields = cap_fld_q;
    assign shb_opa    = cap_a_q;
    assign shb_opb    = cap_b_q;
    assign inj_target = tgt_q;
    assign rt_valid   = rt_valid_q;
    assign rt_class   = rt_class_q;
    assign ill_valid  = ill_valid_q;
    assign ill_opcode = ill_opc_q;

    // R1: a route result follows an accepted instruction
    a_r1_result_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        rt_valid |-> $past(dec_valid && dec_ready));

    // R4: shadow write only after a trap was accepted
    a_r4_shadow_after_trap: assert property (@(posedge clk) disable iff (!rst_n)
        shb_we |-> $past(dec_valid && dec_ready && cur_cls == RT_TRAP));

    // R6: decode is held while the branch is injected
    a_r6_hold_on_inject: assert property (@(posedge clk) disable iff (!rst_n)
        inj_valid |-> !dec_ready);

    // R7: an illegal op writes no shadow and injects nothing
    a_r7_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ill_valid |-> (!shb_we && !inj_valid));

    // R7: the latched opcode changes only with an exception
    a_r7_ill_opcode_held: assert property (@(posedge clk) disable iff (!rst_n)
        !ill_valid |-> $stable(ill_opcode));

endmodule

// File: tb/sim_opdisp_trap_unit.sv
`timescale 1ns/1ps
module sim_opdisp_trap_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [7:0]  dec_opcode = '0;
    logic [15:0] dec_fields = '0;
    logic [31:0] dec_opa = '0;
    logic [31:0] dec_opb = '0;
    logic        dec_ready;
    logic        tbl_we = 1'b0;
    logic [1:0]  tbl_dom = '0;
    logic [7:0]  tbl_opc = '0;
    logic [1:0]  tbl_route = '0;
    logic        dom_we = 1'b0;
    logic [1:0]  dom_sel = '0;
    logic        base_we = 1'b0;
    logic [31:0] base_val = '0;
    logic        hdl_return = 1'b0;
    logic        rt_valid;
    logic [1:0]  rt_class;
    logic        shb_we;
    logic [7:0]  shb_opcode;
    logic [15:0] shb_fields;
    logic [31:0] shb_opa;
    logic [31:0] shb_opb;
    logic        inj_valid;
    logic [31:0] inj_target;
    logic        ill_valid;
    logic [7:0]  ill_opcode;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    opdisp_trap_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_opcode(dec_opcode), .dec_fields(dec_fields),
        .dec_opa(dec_opa), .dec_opb(dec_opb), .dec_ready(dec_ready),
        .tbl_we(tbl_we), .tbl_dom(tbl_dom), .tbl_opc(tbl_opc), .tbl_route(tbl_route),
        .dom_we(dom_we), .dom_sel(dom_sel), .base_we(base_we), .base_val(base_val),
        .hdl_return(hdl_return),
        .rt_valid(rt_valid), .rt_class(rt_class),
        .shb_we(shb_we), .shb_opcode(shb_opcode), .shb_fields(shb_fields),
        .shb_opa(shb_opa), .shb_opb(shb_opb),
        .inj_valid(inj_valid), .inj_target(inj_target),
        .ill_valid(ill_valid), .ill_opcode(ill_opcode)
    );

    // {domain, opcode, expected route}; traps handled by directed tests
    localparam logic [11:0] VEC [8] = '{
        {2'd0, 8'h00, 2'd0},
        {2'd0, 8'h10, 2'd1},
        {2'd0, 8'h30, 2'd3},
        {2'd1, 8'h10, 2'd3},
        {2'd1, 8'h20, 2'd0},
        {2'd2, 8'h05, 2'd1},
        {2'd3, 8'h10, 2'd0},
        {2'd2, 8'h10, 2'd0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_tbl(input logic [1:0] d, input logic [7:0] o, input logic [1:0] r);
        @(negedge clk);
        tbl_we = 1'b1; tbl_dom = d; tbl_opc = o; tbl_route = r;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic set_dom(input logic [1:0] d);
        @(negedge clk);
        dom_we = 1'b1; dom_sel = d;
        @(negedge clk);
        dom_we = 1'b0;
    endtask

    task automatic set_base(input logic [31:0] b);
        @(negedge clk);
        base_we = 1'b1; base_val = b;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    task automatic issue(input logic [7:0] o, input logic [15:0] f,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        dec_valid = 1'b1; dec_opcode = o; dec_fields = f; dec_opa = a; dec_opb = b;
        @(negedge clk);
        dec_valid = 1'b0;
        #1;
    endtask

    task automatic ret_pulse();
        @(negedge clk);
        hdl_return = 1'b1;
        @(negedge clk);
        hdl_return = 1'b0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 ready", dec_ready, 1);
        chk("R10 rt_valid", rt_valid, 0);
        chk("R10 shb_we", shb_we, 0);
        chk("R10 inj_valid", inj_valid, 0);
        chk("R10 ill_valid", ill_valid, 0);
        chk("R10 ill_opcode", ill_opcode, 0);
        rst_n = 1'b1;
        issue(8'h77, 0, 0, 0);
        chk("R10 default route hw", rt_class, 0);

        // R2 program tables
        wr_tbl(0, 8'h10, 1);
        wr_tbl(0, 8'h20, 2);
        wr_tbl(0, 8'h30, 3);
        wr_tbl(1, 8'h10, 3);
        wr_tbl(2, 8'h05, 1);

        // R1 R2 vector walk
        for (int i = 0; i < 8; i++) begin
            set_dom(VEC[i][11:10]);
            issue(VEC[i][9:2], 0, 0, 0);
            chk($sformatf("R1 R2 vec%0d valid", i), rt_valid, 1);
            chk($sformatf("R1 R2 vec%0d class", i), rt_class, VEC[i][1:0]);
            chk($sformatf("R7 vec%0d ill", i), ill_valid, (VEC[i][1:0] == 2'd3));
        end

        // R3 same-cycle table write
        set_dom(0);
        @(negedge clk);
        tbl_we = 1'b1; tbl_dom = 0; tbl_opc = 8'h40; tbl_route = 3;
        dec_valid = 1'b1; dec_opcode = 8'h40;
        @(negedge clk);
        tbl_we = 1'b0; dec_valid = 1'b0; #1;
        chk("R3 write not seen same cycle", rt_class, 0);
        issue(8'h40, 0, 0, 0);
        chk("R3 write seen next", rt_class, 3);

        // R3 same-cycle domain switch
        @(negedge clk);
        dom_we = 1'b1; dom_sel = 1; dec_valid = 1'b1; dec_opcode = 8'h10;
        @(negedge clk);
        dom_we = 1'b0; dec_valid = 1'b0; #1;
        chk("R3 switch not seen same cycle", rt_class, 1);
        issue(8'h10, 0, 0, 0);
        chk("R3 switch seen next", rt_class, 3);
        set_dom(0);

        // R8 back-to-back
        @(negedge clk);
        dec_valid = 1'b1; dec_opcode = 8'h00; #1;
        chk("R8 ready first", dec_ready, 1);
        @(negedge clk);
        dec_opcode = 8'h10; #1;
        chk("R8 ready second", dec_ready, 1);
        chk("R8 first class", rt_class, 0);
        @(negedge clk);
        dec_valid = 1'b0; #1;
        chk("R8 second valid", rt_valid, 1);
        chk("R8 second class", rt_class, 1);

        // R4 R5 R6 trap
        set_base(32'h0000_1000);
        issue(8'h20, 16'hBEEF, 32'h1111_1111, 32'h2222_2222);
        chk("R1 trap class", rt_class, 2);
        chk("R4 shb_we", shb_we, 1);
        chk("R4 shb_opcode", shb_opcode, 8'h20);
        chk("R4 shb_fields", shb_fields, 16'hBEEF);
        chk("R4 shb_opa", shb_opa, 32'h1111_1111);
        chk("R4 shb_opb", shb_opb, 32'h2222_2222);
        chk("R5 inj_valid", inj_valid, 1);
        chk("R5 inj_target", inj_target, 32'h0000_1200);
        chk("R6 stall on inject", dec_ready, 0);
        @(negedge clk); #1;
        chk("R4 shb_we one cycle", shb_we, 0);
        chk("R5 inj one cycle", inj_valid, 0);

        // R8 non-trap while owned
        issue(8'h10, 0, 0, 0);
        chk("R8 micro while owned", rt_class, 1);

        // R9 second trap stalls until return
        @(negedge clk);
        dec_valid = 1'b1; dec_opcode = 8'h20; dec_fields = 16'h1234;
        dec_opa = 32'hA; dec_opb = 32'hB; #1;
        chk("R9 stall", dec_ready, 0);
        @(negedge clk); #1;
        chk("R9 still stalled", dec_ready, 0);
        chk("R9 nothing injected", inj_valid, 0);
        chk("R9 no result", rt_valid, 0);
        @(negedge clk);
        hdl_return = 1'b1;
        @(negedge clk);
        hdl_return = 1'b0; #1;
        chk("R9 ready after return", dec_ready, 1);
        @(negedge clk);
        dec_valid = 1'b0; #1;
        chk("R9 trap taken", inj_valid, 1);
        chk("R9 shadow fields", shb_fields, 16'h1234);
        @(negedge clk);
        ret_pulse();

        // R5 other base and opcode
        wr_tbl(0, 8'hFF, 2);
        set_base(32'h8000_0000);
        issue(8'hFF, 0, 0, 0);
        chk("R5 target high", inj_target, 32'h8000_0FF0);
        @(negedge clk);
        ret_pulse();

        // R7 disabled opcode and hold
        issue(8'h30, 0, 0, 0);
        chk("R7 ill_valid", ill_valid, 1);
        chk("R7 ill_opcode", ill_opcode, 8'h30);
        chk("R7 no shadow", shb_we, 0);
        chk("R7 no inject", inj_valid, 0);
        issue(8'h00, 0, 0, 0);
        chk("R7 pulse ends", ill_valid, 0);
        chk("R7 opcode held", ill_opcode, 8'h30);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule